// File: doc/BRIEF.md
# Auto-ranging gated frequency counter

This block measures the rate of a pulse stream and presents it as a four-digit decimal reading with a maximum of 3999, in the style of a 3-3/4 digit meter. A free-running gate timer splits the oscillator clock into fixed measurement windows. With the default setting a window lasts 40000 clock cycles, which is one second at a 40 kHz oscillator. During each window, input events pass through a decade prescaler and a saturating BCD counter counts them.

When a window ends, a range controller checks the count. An overflow moves the prescaler up one decade. A count below the under-range limit moves it down one decade. In either case the window's result is thrown away, so a reading taken partly on one range and partly on another never reaches the outputs. Otherwise the count is latched, together with the decimal-point position that belongs to the active range, and a one-cycle strobe marks the update.

A hold input freezes the range. In that state every window is latched, including an overflowed one. Input level conversion and display driving take place outside this block.

Top module: `autorange_freq_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to the lowest range (divide by 1) and clears `reading_bcd`, `dp_sel`, `over_flag` and `reading_valid` to zero.
- R2: Measurement windows are exactly `GATE_LEN` clock cycles long and run back to back from reset release. `reading_valid` is high for exactly one cycle, in the cycle after the last cycle of a window whose result is kept.
- R3: A cycle in which `pulse_in` is sampled high is one input event. The prescaler passes one count for every `PRESCALE_BASE**range` events, with range 0..3. Both the prescaler and the counter restart at every window boundary.
- R4: A kept reading is the number of prescaled counts in the whole window, including its last cycle. It is output as four BCD digits, with the thousands digit in bits [15:12] and the units digit in bits [3:0].
- R5: If a window's count exceeds `FULL_SCALE`, the range is below 3 and `hold_range` is low, the range rises by one. That window produces no strobe, and the outputs keep their previous values.
- R6: If a window's count is below `UNDER_LIMIT`, there is no overflow, the range is above 0 and `hold_range` is low, the range falls by one. That window produces no strobe, and the outputs keep their previous values.
- R7: A kept reading carries a decimal-point select based on the active range: range 0 gives `dp_sel` 3'b100, range 1 gives 3'b010, range 2 gives 3'b001, and range 3 gives 3'b000 (no point). At most one bit is ever set.
- R8: While `hold_range` is high, the range does not change and every window is kept, whatever its count.
- R9: A kept window that overflowed sets `over_flag` to 1 and `reading_bcd` to 16'h0000. A kept window that did not overflow clears `over_flag`. A kept reading without the flag never exceeds `FULL_SCALE`.
- R10: Between strobes, `reading_bcd`, `dp_sel` and `over_flag` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Synchronised input event, one count per cycle sampled high |
| hold_range | input | 1 | Freezes the range and keeps every window |
| reading_bcd | output | 16 | Latched four-digit BCD reading |
| dp_sel | output | 3 | One-hot decimal-point select, zero on the top range |
| over_flag | output | 1 | Latched overflow indication |
| reading_valid | output | 1 | One-cycle strobe when a new reading is latched |

## Verification
The bench builds the block with `GATE_LEN` = 1000, `FULL_SCALE` = 99, `UNDER_LIMIT` = 10 and `PRESCALE_BASE` = 2. With these values, a single input pattern can climb through all four ranges in a few windows and reach the overflow flag on the top range. Slower patterns then walk the range back down. The short windows allow many window boundaries, hold intervals and range changes within the run, and the input rate never needs to exceed one event per cycle.

// File: rtl/freqc_pkg.sv
// Shared constants and helpers for the auto-ranging frequency counter.
// Assumes four decimal digits and four decade ranges.
package freqc_pkg;
    localparam int DIGITS   = 4;
    localparam int BCD_W    = 4 * DIGITS;
    localparam int RANGES   = 4;
    localparam int RANGE_W  = 2;

    // Integer power, used at elaboration for prescale divisors.
    function automatic int unsigned ipow(input int unsigned b, input int unsigned e);
        int unsigned r;
        r = 1;
        for (int i = 0; i < int'(e); i++) r = r * b;
        return r;
    endfunction

    // Binary-to-BCD for elaboration-time limits.
    function automatic logic [BCD_W-1:0] to_bcd(input int unsigned v);
        logic [BCD_W-1:0] r;
        int unsigned t;
        r = '0;
        t = v;
        for (int i = 0; i < DIGITS; i++) begin
            r[i*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    // Decimal-point select for a range: leftmost point on range 0, none on range 3.
    function automatic logic [2:0] dp_for_range(input logic [RANGE_W-1:0] rg);
        case (rg)
            2'd0:    return 3'b100;
            2'd1:    return 3'b010;
            2'd2:    return 3'b001;
            default: return 3'b000;
        endcase
    endfunction
endpackage

// File: rtl/freqc_gate_timer.sv
// Gate timer: free-running window counter of GATE_LEN cycles.
// Flags the final cycle of each window. Assumes GATE_LEN >= 2.
module freqc_gate_timer #(
    parameter int GATE_LEN = 40000
) (
    input  logic clk,
    input  logic rst_n,
    output logic gate_last
);
    localparam int GW = $clog2(GATE_LEN);

    logic [GW-1:0] tick_q;

    assign gate_last = (tick_q == GW'(GATE_LEN - 1));

    // Advance the window position, wrapping after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         tick_q <= '0;
        else if (gate_last) tick_q <= '0;
        else                tick_q <= tick_q + 1'b1;
    end
endmodule

// File: rtl/freqc_prescaler.sv
// Decade prescaler: passes one count per BASE**range input events.
// Assumes range changes only together with clr.
module freqc_prescaler
    import freqc_pkg::*;
#(
    parameter int BASE = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [RANGE_W-1:0] range_sel,
    input  logic               event_in,
    output logic               count_out
);
    localparam int unsigned DIV_MAX = ipow(BASE, RANGES - 1);
    localparam int PW = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

    logic [PW-1:0] acc_q;
    logic [PW-1:0] last_val;

    // Last accumulator value before a count is passed, per range.
    always_comb begin
        case (range_sel)
            2'd0:    last_val = PW'(ipow(BASE, 0) - 1);
            2'd1:    last_val = PW'(ipow(BASE, 1) - 1);
            2'd2:    last_val = PW'(ipow(BASE, 2) - 1);
            default: last_val = PW'(ipow(BASE, 3) - 1);
        endcase
    end

    assign count_out = event_in && (acc_q == last_val);

    // Accumulate events, wrapping when a count is passed.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc_q <= '0;
        else if (count_out) acc_q <= '0;
        else if (event_in)  acc_q <= acc_q + 1'b1;
    end
endmodule

// File: rtl/freqc_bcd_counter.sv
// Saturating BCD counter with sticky overflow.
// Exposes its next value so a window's last count can be latched.
module freqc_bcd_counter
    import freqc_pkg::*;
#(
    parameter int FULL_SCALE = 3999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [BCD_W-1:0] cnt_next,
    output logic             ovf_next
);
    localparam logic [BCD_W-1:0] FS_BCD = to_bcd(FULL_SCALE);

    logic [BCD_W-1:0] cnt_q;
    logic             ovf_q;
    logic [BCD_W-1:0] stepped;
    logic [DIGITS:0]  carry;
    logic             at_top;

    assign carry[0] = inc;

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        assign carry[d+1] = carry[d] && (cnt_q[d*4 +: 4] == 4'd9);
        assign stepped[d*4 +: 4] = !carry[d] ? cnt_q[d*4 +: 4] :
                                   (cnt_q[d*4 +: 4] == 4'd9) ? 4'd0 :
                                   cnt_q[d*4 +: 4] + 4'd1;
    end

    assign at_top   = inc && (cnt_q == FS_BCD);
    assign cnt_next = at_top ? cnt_q : stepped;
    assign ovf_next = ovf_q || at_top;

    // Hold the running count; clear at each window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_next;
            ovf_q <= ovf_next;
        end
    end
endmodule

// File: rtl/autorange_freq_counter.sv
// Auto-ranging gated frequency counter top.
// Counts prescaled events per window, steps range on over/under-range,
// and latches kept readings with a one-cycle strobe.
// Assumes pulse_in is already synchronous to clk.
module autorange_freq_counter
    import freqc_pkg::*;
#(
    parameter int GATE_LEN      = 40000,
    parameter int FULL_SCALE    = 3999,
    parameter int UNDER_LIMIT   = 400,
    parameter int PRESCALE_BASE = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             hold_range,
    output logic [BCD_W-1:0] reading_bcd,
    output logic [2:0]       dp_sel,
    output logic             over_flag,
    output logic             reading_valid
);
    localparam logic [BCD_W-1:0] UL_BCD = to_bcd(UNDER_LIMIT);
    localparam logic [RANGE_W-1:0] TOP_RANGE = RANGE_W'(RANGES - 1);

    logic [RANGE_W-1:0] range_q;
    logic               gate_last;
    logic               scaled;
    logic [BCD_W-1:0]   cnt_next;
    logic               ovf_next;
    logic               go_up;
    logic               go_down;

    freqc_gate_timer #(.GATE_LEN(GATE_LEN)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_last (gate_last)
    );

    freqc_prescaler #(.BASE(PRESCALE_BASE)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (gate_last),
        .range_sel (range_q),
        .event_in  (pulse_in),
        .count_out (scaled)
    );

    freqc_bcd_counter #(.FULL_SCALE(FULL_SCALE)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (gate_last),
        .inc      (scaled),
        .cnt_next (cnt_next),
        .ovf_next (ovf_next)
    );

    // Range decision for the window now ending.
    assign go_up   = !hold_range && ovf_next && (range_q != TOP_RANGE);
    assign go_down = !hold_range && !ovf_next && (cnt_next < UL_BCD)
                     && (range_q != '0);

    // Step the range or latch the window's reading at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_q       <= '0;
            reading_bcd   <= '0;
            dp_sel        <= '0;
            over_flag     <= 1'b0;
            reading_valid <= 1'b0;
        end else begin
            reading_valid <= 1'b0;
            if (gate_last) begin
                if (go_up) begin
                    range_q <= range_q + 1'b1;
                end else if (go_down) begin
                    range_q <= range_q - 1'b1;
                end else begin
                    reading_bcd   <= ovf_next ? '0 : cnt_next;
                    over_flag     <= ovf_next;
                    dp_sel        <= dp_for_range(range_q);
                    reading_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/autorange_freq_counter_chk.sv
// Property checker for the auto-ranging frequency counter, bound to the top.
module autorange_freq_counter_chk
    import freqc_pkg::*;
#(
    parameter int FULL_SCALE = 3999
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hold_range,
    input logic [RANGE_W-1:0] range_q,
    input logic [BCD_W-1:0]   reading_bcd,
    input logic [2:0]         dp_sel,
    input logic               over_flag,
    input logic               reading_valid
);
    int unsigned shown;

    // Decode the displayed digits to a plain number.
    always_comb begin
        shown = 0;
        for (int i = DIGITS - 1; i >= 0; i--)
            shown = shown * 10 + int'(reading_bcd[i*4 +: 4]);
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reading_valid |=> !reading_valid);                                   // R2
    AST_DIGITS_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (reading_bcd[3:0] <= 4'd9) && (reading_bcd[7:4] <= 4'd9) &&
        (reading_bcd[11:8] <= 4'd9) && (reading_bcd[15:12] <= 4'd9));       // R4
    AST_KEEP_SAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        reading_valid |-> $stable(range_q));                                 // R5
    AST_DP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dp_sel));                                                   // R7
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_range |=> $stable(range_q));                                    // R8
    AST_OVER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        over_flag |-> (reading_bcd == '0));                                  // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !over_flag |-> (shown <= FULL_SCALE));                               // R9
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !reading_valid |-> ($stable(reading_bcd) && $stable(dp_sel) && $stable(over_flag))); // R10
endmodule

bind autorange_freq_counter autorange_freq_counter_chk #(.FULL_SCALE(FULL_SCALE)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hold_range    (hold_range),
    .range_q       (range_q),
    .reading_bcd   (reading_bcd),
    .dp_sel        (dp_sel),
    .over_flag     (over_flag),
    .reading_valid (reading_valid)
);

// File: tb/autorange_freq_counter_bench.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module autorange_freq_counter_bench;
    localparam int GL   = 1000;
    localparam int FS   = 99;
    localparam int UL   = 10;
    localparam int BASE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pulse_in = 1'b0;
    logic        hold_range = 1'b0;
    logic [15:0] reading_bcd;
    logic [2:0]  dp_sel;
    logic        over_flag;
    logic        reading_valid;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int period = 0;
    int cyc = 0;

    // Reference model state
    int   m_range, m_gate, m_pre, m_cnt, m_div, m_read;
    logic m_valid, m_over;
    logic [2:0] m_dp;

    always #2.5 clk = ~clk;

    autorange_freq_counter #(
        .GATE_LEN(GL), .FULL_SCALE(FS), .UNDER_LIMIT(UL), .PRESCALE_BASE(BASE)
    ) u_autorange_freq_counter (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .hold_range(hold_range),
        .reading_bcd(reading_bcd), .dp_sel(dp_sel), .over_flag(over_flag),
        .reading_valid(reading_valid)
    );

    function automatic logic [15:0] num_to_bcd(input int v);
        logic [15:0] r;
        r = '0;
        for (int i = 0; i < 4; i++) r[i*4 +: 4] = 4'((v / (10 ** i)) % 10);
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
        end
    endtask

    // Pulse source: one event every `period` cycles, driven away from the edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        pulse_in <= (period > 0) && ((cyc % period) == 0);
    end

    // Reference model of the requirements, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_range = 0; m_gate = 0; m_pre = 0; m_cnt = 0;
            m_valid = 0; m_over = 0; m_read = 0; m_dp = 3'b000;
        end else begin
            m_valid = 0;
            m_div = BASE ** m_range;
            if (pulse_in) begin
                if (m_pre == m_div - 1) begin m_pre = 0; m_cnt++; end
                else m_pre++;
            end
            if (m_gate == GL - 1) begin
                if (!hold_range && m_cnt > FS && m_range < 3) m_range++;
                else if (!hold_range && m_cnt <= FS && m_cnt < UL && m_range > 0) m_range--;
                else begin
                    m_valid = 1;
                    m_over = (m_cnt > FS);
                    m_read = m_over ? 0 : m_cnt;
                    m_dp = (m_range == 0) ? 3'b100 : (m_range == 1) ? 3'b010 :
                           (m_range == 2) ? 3'b001 : 3'b000;
                end
                m_gate = 0; m_cnt = 0; m_pre = 0;
            end else m_gate++;
        end
    end

    // Compare every output with the model each cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 reading_valid", int'(reading_valid), int'(m_valid));
            check("R4 reading_bcd", int'(reading_bcd), int'(num_to_bcd(m_read)));
            check("R7 dp_sel", int'(dp_sel), int'(m_dp));
            check("R9 over_flag", int'(over_flag), int'(m_over));
        end
    end

    task automatic wait_valid(input string req);
        int n;
        n = 0;
        @(negedge clk);
        while (!reading_valid && n < 6000) begin @(negedge clk); n++; end
        check({req, " strobe seen"}, int'(reading_valid), 1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 reading_bcd", int'(reading_bcd), 0);
        check("R1 dp_sel", int'(dp_sel), 0);
        check("R1 over_flag", int'(over_flag), 0);
        check("R1 reading_valid", int'(reading_valid), 0);
        rst_n = 1'b1;

        // R3 R5: 250 events/window climb to range 2 -> 250/4 = 62
        period = 4;
        wait_valid("R5");
        check("R5 R3 reading", int'(reading_bcd), 16'h0062);
        check("R7 dp range2", int'(dp_sel), 3'b001);

        // R9: every cycle -> overflow on the top range
        period = 1;
        wait_valid("R9");
        wait_valid("R9");
        check("R9 over_flag", int'(over_flag), 1);
        check("R9 blank", int'(reading_bcd), 0);
        check("R7 dp range3", int'(dp_sel), 3'b000);

        // R8: slow input under hold stays on range 3: 10/8 = 1
        hold_range = 1'b1;
        period = 100;
        wait_valid("R8");
        wait_valid("R8");
        check("R8 reading", int'(reading_bcd), 16'h0001);
        check("R8 dp", int'(dp_sel), 3'b000);
        check("R10 over cleared", int'(over_flag), 0);

        // R6: release hold, range walks down to 0: 10 events kept
        hold_range = 1'b0;
        wait_valid("R6");
        check("R6 reading", int'(reading_bcd), 16'h0010);
        check("R6 R7 dp range0", int'(dp_sel), 3'b100);

        // R4: 999 events in a window on range 0 overflow, so check 50/window
        period = 20;
        wait_valid("R4");
        wait_valid("R4");
        check("R4 reading", int'(reading_bcd), 16'h0050);
        repeat (10) @(negedge clk);
        check("R10 held", int'(reading_bcd), 16'h0050);
        finish_run();
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule